// File: doc/BRIEF.md
# Performance Counter Bank

This block is a bank of hardware performance counters behind a simple word-addressed register port. It holds `NUM_CTR` 32-bit event counters, each with its own event-type register, and one 64-bit cycle counter with a filter register. Each event counter advances on its own strobe input. The cycle counter advances on every clock. Counting takes place only when the global run bit in the control register is set and the counter's own enable bit is set.

Software manages the bank through a control register that carries read-only identity fields and two self-clearing reset actions. Enables and interrupt enables each sit behind a set/clear register pair. A sticky overflow status register is cleared by writing ones to it. A selector register gives indirect access to any one counter's type and value. The interrupt output is raised when an overflow flag has its interrupt enable set.

The register port has single-cycle writes. Reads are registered: `rdata` carries the value of the word addressed in the cycle where `rd_en` was high, and it appears after the next rising edge. Word addresses are: control 0x00, enable-set 0x01, enable-clear 0x02, overflow status/clear 0x03, interrupt-enable set 0x04, interrupt-enable clear 0x05, selector 0x06, selected type 0x07, selected count 0x08, cycle low 0x09, cycle high 0x0A, cycle filter 0x0B, event type i at 0x10+i, event count i at 0x20+i (NUM_CTR at most 16).

Top module: `pmu_bank`

## Requirements
- R1: After reset all counters, enables, interrupt enables, overflow flags and `irq_o` are zero, and the control register reads {IMPL_CODE[31:24], ID_CODE[23:16], NUM_CTR[15:11], zeros}.
- R2: Control bits 0 (run), 5:3 (spare controls) and 6 (long cycle overflow) are writable and read back as written; writes to bits 7 and above have no effect and those bits always read the identity fields.
- R3: Writing control bit 1 as one zeroes every event counter, and writing bit 2 as one zeroes both halves of the cycle counter; both bits always read back zero.
- R4: The enable-set and enable-clear addresses both read the enable mask (bit i = event counter i, bit 31 = cycle counter); ones written to set enable, ones written to clear disable, and set writes to bits of unimplemented counters are ignored.
- R5: The interrupt-enable set/clear pair follows the same rules as R4, with the same bit positions.
- R6: An enabled event counter increments by one in each cycle in which its strobe is high while run is set; a counter whose enable bit is clear does not change.
- R7: The cycle counter increments by one per clock while run and enable bit 31 are set; its low and high words are loaded independently by writes.
- R8: An event counter that steps from 0xFFFFFFFF wraps to zero and sets overflow bit i; counters that do not wrap leave their flags clear.
- R9: With control bit 6 clear, a carry out of cycle-counter bit 31 sets overflow bit 31; with bit 6 set, only a carry out of bit 63 sets it.
- R10: Overflow flags are sticky; writing ones to the overflow address clears the matching flags, and zeros leave them unchanged.
- R11: `irq_o` is high in the cycle after (overflow flags AND interrupt enables) is nonzero, and low in the cycle after it is zero.
- R12: Each type register keeps bits 31, 30 and 11:0 of a write and reads the other bits as zero.
- R13: With selector value n below NUM_CTR, the selected-type and selected-count addresses alias counter n's own registers; selector 31 aliases the cycle filter register; any other value reads zero there and ignores writes.
- R14: While the run bit is clear, no counter advances, whatever its enable bit and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_i | input | NUM_CTR | Per-counter event strobes |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A counter that advances while run is clear, or that misses a strobe, shows up as a wrong count the next time the counter is read. A count also covers a whole run of strobes, so one missed cycle anywhere in that run is enough to make the final value wrong. A wrong wrap or long-overflow decision appears in the overflow status at the first read after the carry. A wrong interrupt-enable or overflow state appears on `irq_o` one cycle after it arises. Aliasing faults in the selector appear as a mismatch between the direct and indirect views of the same register at the next read.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h00;
  localparam logic [ADDR_W-1:0] A_ENSET   = 6'h01;
  localparam logic [ADDR_W-1:0] A_ENCLR   = 6'h02;
  localparam logic [ADDR_W-1:0] A_OVF     = 6'h03;
  localparam logic [ADDR_W-1:0] A_IESET   = 6'h04;
  localparam logic [ADDR_W-1:0] A_IECLR   = 6'h05;
  localparam logic [ADDR_W-1:0] A_SEL     = 6'h06;
  localparam logic [ADDR_W-1:0] A_SELTYPE = 6'h07;
  localparam logic [ADDR_W-1:0] A_SELCNT  = 6'h08;
  localparam logic [ADDR_W-1:0] A_CYCLO   = 6'h09;
  localparam logic [ADDR_W-1:0] A_CYCHI   = 6'h0A;
  localparam logic [ADDR_W-1:0] A_CYCFILT = 6'h0B;
  localparam logic [1:0]        PAGE_TYPE = 2'b01;
  localparam logic [1:0]        PAGE_CNT  = 2'b10;

  // Type register keeps the two exclusion bits and the event number.
  localparam logic [DATA_W-1:0] TYPE_KEEP = 32'hC000_0FFF;
  localparam int                CYC_BIT   = 31;
  localparam logic [4:0]        SEL_CYC   = 5'd31;
endpackage

// File: rtl/pmu_mask_pair.sv
module pmu_mask_pair
  import pmu_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = set_we ? (wdata & MASK) : '0;
    clr_bits = clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_type,
  input  logic              wr_cnt,
  input  logic              clear,
  input  logic              inc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] type_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              wrap_o
);
  assign wrap_o = inc && !clear && !wr_cnt && (&cnt_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      type_o <= '0;
    end else begin
      if (clear)       cnt_o <= '0;
      else if (wr_cnt) cnt_o <= wdata;
      else if (inc)    cnt_o <= cnt_o + 1'b1;
      if (wr_type)     type_o <= wdata & TYPE_KEEP;
    end
  end
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                wr_filt,
  input  logic                clear,
  input  logic                inc,
  input  logic                long_mode,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0]   filt_o,
  output logic                wrap_o
);
  logic at_top;

  always_comb begin
    at_top = long_mode ? (&cnt_o) : (&cnt_o[DATA_W-1:0]);
    wrap_o = inc && !clear && !wr_lo && !wr_hi && at_top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      filt_o <= '0;
    end else begin
      if (clear) begin
        cnt_o <= '0;
      end else if (wr_lo || wr_hi) begin
        if (wr_lo) cnt_o[DATA_W-1:0]        <= wdata;
        if (wr_hi) cnt_o[2*DATA_W-1:DATA_W] <= wdata;
      end else if (inc) begin
        cnt_o <= cnt_o + 1'b1;
      end
      if (wr_filt) filt_o <= wdata & TYPE_KEEP;
    end
  end
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int         NUM_CTR   = 4,
  parameter logic [7:0] ID_CODE   = 8'h3C,
  parameter logic [7:0] IMPL_CODE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CTR-1:0] evt_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (32'h1 << CYC_BIT) | ((32'h1 << NUM_CTR) - 32'h1);
  localparam logic [ADDR_W-1:0] TYPE_BASE = {PAGE_TYPE, 4'h0};
  localparam logic [ADDR_W-1:0] CNT_BASE  = {PAGE_CNT, 4'h0};

  // control state
  logic       ctrl_e_q, ctrl_lc_q;
  logic [2:0] ctrl_x_q;
  logic [4:0] sel_q;
  logic [DATA_W-1:0] ctrl_rd;
  logic ctrl_we, clr_ev, clr_cyc, sel_cyc;

  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign clr_ev  = ctrl_we && wdata[1];
  assign clr_cyc = ctrl_we && wdata[2];
  assign sel_cyc = (sel_q == SEL_CYC);
  assign ctrl_rd = {IMPL_CODE, ID_CODE, 5'(NUM_CTR), 4'b0, ctrl_lc_q,
                    ctrl_x_q, 2'b00, ctrl_e_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_e_q  <= 1'b0;
      ctrl_lc_q <= 1'b0;
      ctrl_x_q  <= '0;
      sel_q     <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl_e_q  <= wdata[0];
        ctrl_x_q  <= wdata[5:3];
        ctrl_lc_q <= wdata[6];
      end
      if (wr_en && addr == A_SEL) sel_q <= wdata[4:0];
    end
  end

  // enable and interrupt-enable pairs
  logic [DATA_W-1:0] en_q, ie_q, ovf_q, ovf_set;

  pmu_mask_pair #(.MASK(IMPL_MASK)) u_en (
    .clk(clk), .rst(rst),
    .set_we(wr_en && addr == A_ENSET), .clr_we(wr_en && addr == A_ENCLR),
    .wdata(wdata), .q(en_q)
  );

  pmu_mask_pair #(.MASK(IMPL_MASK)) u_ie (
    .clk(clk), .rst(rst),
    .set_we(wr_en && addr == A_IESET), .clr_we(wr_en && addr == A_IECLR),
    .wdata(wdata), .q(ie_q)
  );

  // event counters
  logic [DATA_W-1:0] ev_type [NUM_CTR];
  logic [DATA_W-1:0] ev_cnt  [NUM_CTR];
  logic [NUM_CTR-1:0] ev_wrap;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic wr_t, wr_c;
    assign wr_t = wr_en && ((addr == ADDR_W'(TYPE_BASE + g)) ||
                            (addr == A_SELTYPE && sel_q == 5'(g)));
    assign wr_c = wr_en && ((addr == ADDR_W'(CNT_BASE + g)) ||
                            (addr == A_SELCNT && sel_q == 5'(g)));
    pmu_evt_ctr u_ctr (
      .clk(clk), .rst(rst), .wr_type(wr_t), .wr_cnt(wr_c), .clear(clr_ev),
      .inc(ctrl_e_q && en_q[g] && evt_i[g]), .wdata(wdata),
      .type_o(ev_type[g]), .cnt_o(ev_cnt[g]), .wrap_o(ev_wrap[g])
    );
  end

  // cycle counter
  logic [2*DATA_W-1:0] cyc_cnt;
  logic [DATA_W-1:0]   cyc_filt;
  logic                cyc_wrap;

  pmu_cyc_ctr u_cyc (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && addr == A_CYCLO), .wr_hi(wr_en && addr == A_CYCHI),
    .wr_filt(wr_en && (addr == A_CYCFILT || (addr == A_SELTYPE && sel_cyc))),
    .clear(clr_cyc), .inc(ctrl_e_q && en_q[CYC_BIT]), .long_mode(ctrl_lc_q),
    .wdata(wdata), .cnt_o(cyc_cnt), .filt_o(cyc_filt), .wrap_o(cyc_wrap)
  );

  // overflow status and interrupt
  always_comb begin
    ovf_set = '0;
    ovf_set[NUM_CTR-1:0] = ev_wrap;
    ovf_set[CYC_BIT]     = cyc_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
      irq_o <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~((wr_en && addr == A_OVF) ? wdata : '0)) | ovf_set;
      irq_o <= |(ovf_q & ie_q);
    end
  end

  // read path
  logic [DATA_W-1:0] sel_type, sel_cnt, page_rd, rd_mux;

  always_comb begin
    sel_type = sel_cyc ? cyc_filt : '0;
    sel_cnt  = '0;
    page_rd  = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == 5'(i)) begin
        sel_type = ev_type[i];
        sel_cnt  = ev_cnt[i];
      end
      if (addr[3:0] == 4'(i)) begin
        if (addr[5:4] == PAGE_TYPE) page_rd = ev_type[i];
        if (addr[5:4] == PAGE_CNT)  page_rd = ev_cnt[i];
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:           rd_mux = ctrl_rd;
      A_ENSET, A_ENCLR: rd_mux = en_q;
      A_OVF:            rd_mux = ovf_q;
      A_IESET, A_IECLR: rd_mux = ie_q;
      A_SEL:            rd_mux = {27'b0, sel_q};
      A_SELTYPE:        rd_mux = sel_type;
      A_SELCNT:         rd_mux = sel_cnt;
      A_CYCLO:          rd_mux = cyc_cnt[DATA_W-1:0];
      A_CYCHI:          rd_mux = cyc_cnt[2*DATA_W-1:DATA_W];
      A_CYCFILT:        rd_mux = cyc_filt;
      default:          rd_mux = page_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic                ctrl_e,
  input logic [DATA_W-1:0]   en_q,
  input logic [DATA_W-1:0]   ie_q,
  input logic [DATA_W-1:0]   ovf_q,
  input logic                irq_o,
  input logic [2*DATA_W-1:0] cyc_cnt
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (32'h1 << CYC_BIT) | ((32'h1 << NUM_CTR) - 32'h1);

  AST_EN_IMPL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~IMPL_MASK) == '0); // R4
  AST_IE_IMPL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ie_q & ~IMPL_MASK) == '0); // R5
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|(ovf_q & ie_q)) |=> irq_o); // R11
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|(ovf_q & ie_q)) |=> !irq_o); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R10
  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_e && !wr_en) |=> $stable(cyc_cnt)); // R14
endmodule

bind pmu_bank pmu_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .ctrl_e(ctrl_e_q),
  .en_q(en_q), .ie_q(ie_q), .ovf_q(ovf_q), .irq_o(irq_o), .cyc_cnt(cyc_cnt)
);

// File: tb/pmu_bank_bench.sv
module pmu_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [31:0] ID_WORD = 32'h7E3C_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] ev = '0;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_bank #(.NUM_CTR(N), .ID_CODE(8'h3C), .IMPL_CODE(8'h7E)) u_pmu_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_i(ev), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    rd(6'h00, v); chk("R1 ctrl", v, ID_WORD);
    rd(6'h01, v); chk("R1 enable", v, 32'h0);
    rd(6'h03, v); chk("R1 overflow", v, 32'h0);
    rd(6'h20, v); chk("R1 count0", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R2 ctrl writable bits, R3 action bits zero", v, ID_WORD | 32'h79);
    wr(6'h00, 32'h0);
    rd(6'h00, v); chk("R2 ctrl cleared", v, ID_WORD);
  endtask

  task automatic t_enable;
    wr(6'h01, 32'hFFFF_FFFF);
    rd(6'h01, v); chk("R4 set reads implemented", v, 32'h8000_000F);
    rd(6'h02, v); chk("R4 clear view equal", v, 32'h8000_000F);
    wr(6'h02, ~32'h3);
    rd(6'h01, v); chk("R4 clear leaves 0,1", v, 32'h3);
    wr(6'h02, 32'hFFFF_FFFF);
    rd(6'h02, v); chk("R4 all clear", v, 32'h0);
  endtask

  task automatic t_ie;
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R5 ie set implemented", v, 32'h8000_000F);
    rd(6'h05, v); chk("R5 ie clear view", v, 32'h8000_000F);
    wr(6'h05, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R5 ie cleared", v, 32'h0);
  endtask

  task automatic t_type;
    wr(6'h11, 32'hFFFF_FFFF);
    rd(6'h11, v); chk("R12 type mask", v, 32'hC000_0FFF);
    wr(6'h12, 32'h0000_00EA);
    rd(6'h12, v); chk("R12 type event", v, 32'h0000_00EA);
  endtask

  task automatic t_sel;
    wr(6'h06, 32'd1);
    wr(6'h07, 32'h0000_0123);
    rd(6'h11, v); chk("R13 sel type alias", v, 32'h0000_0123);
    wr(6'h08, 32'hDEAD_BEEF);
    rd(6'h21, v); chk("R13 sel count alias", v, 32'hDEAD_BEEF);
    wr(6'h06, 32'd31);
    wr(6'h07, 32'h8000_0000);
    rd(6'h0B, v); chk("R13 sel 31 filter", v, 32'h8000_0000);
    wr(6'h06, 32'd7);
    wr(6'h08, 32'h5);
    rd(6'h08, v); chk("R13 sel unimpl reads zero", v, 32'h0);
    rd(6'h21, v); chk("R13 sel unimpl write ignored", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_count;
    wr(6'h00, 32'h46);
    rd(6'h21, v); chk("R3 event reset", v, 32'h0);
    rd(6'h00, v); chk("R3 action bits read zero", v, ID_WORD | 32'h40);
    wr(6'h01, 32'h3);
    pulse(4'hF);
    rd(6'h20, v); chk("R14 no count while run clear", v, 32'h0);
    wr(6'h00, 32'h41);
    for (int i = 0; i < 3; i++) pulse(4'h1);
    for (int i = 0; i < 2; i++) pulse(4'h3);
    pulse(4'hC);
    wr(6'h00, 32'h40);
    rd(6'h20, v); chk("R6 count0", v, 32'd5);
    rd(6'h21, v); chk("R6 count1", v, 32'd2);
    rd(6'h22, v); chk("R6 disabled count2", v, 32'd0);
  endtask

  task automatic t_wrap;
    wr(6'h00, 32'h46);
    wr(6'h03, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFF0);
    wr(6'h00, 32'h41);
    for (int i = 0; i < 20; i++) pulse(4'h3);
    wr(6'h00, 32'h40);
    rd(6'h20, v); chk("R8 wrapped value", v, 32'h4);
    rd(6'h21, v); chk("R8 plain count", v, 32'd20);
    rd(6'h03, v); chk("R8 flag only on 0", v, 32'h1);
    chk("R11 irq low while masked", {31'b0, irq_o}, 32'h0);
    wr(6'h04, 32'h1);
    chk("R11 irq one cycle later", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R11 irq raised", {31'b0, irq_o}, 32'h1);
    wr(6'h03, 32'h2);
    rd(6'h03, v); chk("R10 sticky under zero write", v, 32'h1);
    wr(6'h03, 32'h1);
    @(negedge clk);
    chk("R11 irq dropped", {31'b0, irq_o}, 32'h0);
    rd(6'h03, v); chk("R10 cleared", v, 32'h0);
    wr(6'h05, 32'hFFFF_FFFF);
    wr(6'h02, 32'hFFFF_FFFF);
  endtask

  task automatic cyc_run(input logic [31:0] hi, input logic [31:0] lo, input logic lc);
    wr(6'h09, lo);
    wr(6'h0A, hi);
    wr(6'h00, {25'b0, lc, 5'b0, 1'b1});
    repeat (9) @(negedge clk);
    wr(6'h00, {25'b0, lc, 6'b0});
  endtask

  task automatic t_cycle;
    wr(6'h03, 32'hFFFF_FFFF);
    wr(6'h01, 32'h8000_0000);
    cyc_run(32'h0, 32'hFFFF_FFFA, 1'b0);
    rd(6'h09, v); chk("R7 cycle low", v, 32'h4);
    rd(6'h0A, v); chk("R7 cycle high carry", v, 32'h1);
    rd(6'h03, v); chk("R9 short overflow", v, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd(6'h09, v); chk("R14 cycle frozen", v, 32'h4);
    wr(6'h03, 32'hFFFF_FFFF);
    cyc_run(32'h1, 32'hFFFF_FFFA, 1'b1);
    rd(6'h0A, v); chk("R9 long high", v, 32'h2);
    rd(6'h03, v); chk("R9 long no flag at 32", v, 32'h0);
    cyc_run(32'hFFFF_FFFF, 32'hFFFF_FFFA, 1'b1);
    rd(6'h0A, v); chk("R9 long wrap high", v, 32'h0);
    rd(6'h03, v); chk("R9 long flag at 64", v, 32'h8000_0000);
    wr(6'h00, 32'h04);
    rd(6'h09, v); chk("R3 cycle reset low", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_enable();
    t_ie();
    t_type();
    t_sel();
    t_count();
    t_wrap();
    t_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule